// File: doc/BRIEF.md
# Three-Wire Register Window Slave

This block is a serial slave for a three-pin control port made of a serial clock, a bidirectional data pin and an active-low enable. All three pins are sampled with the local system clock. A transfer starts when the enable falls. The host then shifts in a nine-bit control word and follows it with a sixteen-bit data word. On a write the host drives the data word. On a read the slave drives it, after a half-cycle bus turnaround, through a data output and a separate output enable.

Behind the port is a small register window. Three argument registers hold parameters for a command. A command register launches the command when it is written. Eight read-only response words come from the surrounding logic. A complete write to the command register gives a one-cycle launch strobe, together with the command word and the three argument words. What the command does is left to the logic around the block.

Top module: `tw_slave`

## Requirements
- R1: After reset, cmd_go_o and sdio_oe_o are low and the command word and all argument words read 0x0000.
- R2: The control word is sent MSB first on rising serial-clock edges: bits 8:6 are the device ID, which must be 3'b101; bit 5 is read (1) or write (0); bits 4:0 are the register index. A write to index 1, 2 or 3 loads the 16 data bits, MSB first, into argument word 0, 1 or 2 and raises no strobe.
- R3: A write to index 0 loads the command word and pulses cmd_go_o high for exactly one system clock. While the pulse is high, the argument outputs show the values written earlier.
- R4: If the enable rises before all 16 data bits of a write have been captured, no register changes and no strobe is raised.
- R5: On a read, sdio_oe_o stays low until the first serial-clock falling edge after the ninth control bit. At that edge the slave drives data bit 15. Each later rising edge presents the next lower bit. sdio_oe_o drops within a few system clocks of the enable rising.
- R6: A read of index 0 returns the command word, a read of index 1 to 3 returns the matching argument word, and a read of index 8 to 15 returns response word (index - 8) from resp_i, where word k is resp_i[16k+15:16k].
- R7: A read of any other index drives 0x0000 with sdio_oe_o high.
- R8: With an ID other than 3'b101, sdio_oe_o never rises during the transfer and the data phase changes no register.
- R9: Writes to response indexes 8 to 15 or to unmapped indexes leave the command word, the argument words and resp readback unchanged, and raise no strobe.
- R10: A transfer closes only when the enable is high and the serial clock then falls once. If the enable drops again before that falling edge, the frame that follows is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sen_n_i | input | 1 | Active-low transfer enable |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data toward the host |
| sdio_oe_o | output | 1 | Drive enable for sdio_o |
| resp_i | input | 128 | Eight 16-bit response words, word k at bits 16k+15:16k |
| cmd_go_o | output | 1 | One-cycle command launch strobe |
| cmd_word_o | output | 16 | Last command word written |
| args_o | output | 48 | Three argument words, word k at bits 16k+15:16k |

## Verification
The hardest case to reach is the closing rule. The enable rises and then falls again before any closing serial-clock pulse, so the next frame has to be ignored even though its bits are perfectly well formed. The stimulus gets there by ending a valid write with only an enable pulse and then sending a second write to the same argument, carrying a different value. The argument must keep the first value, and a normal write afterwards must take effect. Aborted writes and reads with a bad ID follow the same plan: each is followed by a read-back or a port check before the next frame.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WDATA,
    ST_RTURN,
    ST_RDATA,
    ST_SKIP,
    ST_DONE
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int IDW = 3,
  parameter logic [IDW-1:0] DEV_ID = 3'b101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sen_n_s,
  input  logic          sdio_s,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdio_o,
  output logic          sdio_oe_o
);
  localparam int CW = IDW + 1 + AW;
  localparam int MAXB = (CW > DW) ? CW : DW;
  localparam int CNTW = $clog2(MAXB) + 1;
  localparam logic [CNTW-1:0] CTRL_LAST = CNTW'(CW - 1);
  localparam logic [CNTW-1:0] DATA_LAST = CNTW'(DW - 1);

  tw_state_e     state_q, state_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] ctrl_q, ctrl_n, new_ctrl;
  logic [DW-1:0] sh_q, sh_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          oe_q, oe_n, so_q, so_n, wr_q, wr_n;
  logic          sclk_d, rise, fall, active;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign new_ctrl = {ctrl_q[CW-2:0], sdio_s};
  assign active   = (state_q != ST_IDLE) && (state_q != ST_DONE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    ctrl_n  = ctrl_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    oe_n    = oe_q;
    so_n    = so_q;
    wr_n    = 1'b0;
    if (active && sen_n_s) begin
      state_n = ST_DONE;
      oe_n    = 1'b0;
      so_n    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (!sen_n_s) begin
          state_n = ST_CTRL;
          cnt_n   = '0;
        end
        ST_CTRL: if (rise) begin
          ctrl_n = new_ctrl;
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CTRL_LAST) begin
            cnt_n  = '0;
            addr_n = new_ctrl[AW-1:0];
            if (new_ctrl[CW-1 -: IDW] != DEV_ID) begin
              state_n = ST_SKIP;
            end else if (new_ctrl[AW]) begin
              state_n = ST_RTURN;
              sh_n    = rd_data_i;
            end else begin
              state_n = ST_WDATA;
            end
          end
        end
        ST_WDATA: if (rise) begin
          sh_n  = {sh_q[DW-2:0], sdio_s};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == DATA_LAST) begin
            wr_n    = 1'b1;
            state_n = ST_SKIP;
          end
        end
        ST_RTURN: if (fall) begin
          oe_n    = 1'b1;
          so_n    = sh_q[DW-1];
          sh_n    = {sh_q[DW-2:0], 1'b0};
          state_n = ST_RDATA;
        end
        ST_RDATA: if (rise) begin
          so_n = sh_q[DW-1];
          sh_n = {sh_q[DW-2:0], 1'b0};
        end
        ST_SKIP: ;
        ST_DONE: if (fall && sen_n_s) state_n = ST_IDLE;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      so_q    <= 1'b0;
      wr_q    <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      ctrl_q  <= ctrl_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      oe_q    <= oe_n;
      so_q    <= so_n;
      wr_q    <= wr_n;
      sclk_d  <= sclk_s;
    end
  end

  assign rd_addr_o = new_ctrl[AW-1:0];
  assign wr_en_o   = wr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = sh_q;
  assign sdio_o    = so_q;
  assign sdio_oe_o = oe_q;

  AST_WR_WHILE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !$past(sen_n_s)); // R4
  AST_OE_DROPS_ON_SEN: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n_s |=> !sdio_oe_o); // R5
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe_o) |-> $past(fall)); // R5
endmodule

// File: rtl/tw_regs.sv
module tw_regs #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int NUM_ARGS = 3,
  parameter int NUM_RESP = 8,
  parameter int CMD_IDX = 0,
  parameter int ARG_IDX = 1,
  parameter int RESP_IDX = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [AW-1:0]          raddr_i,
  input  logic [NUM_RESP*DW-1:0] resp_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   cmd_go_o,
  output logic [DW-1:0]          cmd_word_o,
  output logic [NUM_ARGS*DW-1:0] args_o
);
  logic [DW-1:0] cmd_q;
  logic          go_q, cmd_we;
  logic [DW-1:0] arg_q [NUM_ARGS];

  assign cmd_we = we_i && (waddr_i == AW'(CMD_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= cmd_we;
      if (cmd_we) cmd_q <= wdata_i;
    end
  end

  generate
    for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
      logic arg_we;
      assign arg_we = we_i && (waddr_i == AW'(ARG_IDX + g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      arg_q[g] <= '0;
        else if (arg_we) arg_q[g] <= wdata_i;
      end
      assign args_o[g*DW +: DW] = arg_q[g];

      AST_ARG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(arg_q[g]) |-> $past(we_i)); // R9
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (raddr_i == AW'(CMD_IDX)) rdata_o = cmd_q;
    for (int i = 0; i < NUM_ARGS; i++)
      if (raddr_i == AW'(ARG_IDX + i)) rdata_o = arg_q[i];
    for (int i = 0; i < NUM_RESP; i++)
      if (raddr_i == AW'(RESP_IDX + i)) rdata_o = resp_i[i*DW +: DW];
  end

  assign cmd_go_o   = go_q;
  assign cmd_word_o = cmd_q;

  AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go_o |=> !cmd_go_o); // R3
  AST_CMD_CHANGES_WITH_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> cmd_go_o); // R3
endmodule

// File: rtl/tw_slave.sv
module tw_slave #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int IDW = 3,
  parameter logic [IDW-1:0] DEV_ID = 3'b101,
  parameter int NUM_ARGS = 3,
  parameter int NUM_RESP = 8,
  parameter int CMD_IDX = 0,
  parameter int ARG_IDX = 1,
  parameter int RESP_IDX = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_i,
  input  logic                   sen_n_i,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe_o,
  input  logic [NUM_RESP*DW-1:0] resp_i,
  output logic                   cmd_go_o,
  output logic [DW-1:0]          cmd_word_o,
  output logic [NUM_ARGS*DW-1:0] args_o
);
  logic [1:0]    rst_pipe;
  logic          rst_n_int;
  logic [2:0]    pins_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  ({sen_n_i, sclk_i, sdio_i}),
    .q_o  (pins_s)
  );

  tw_frame #(.DW(DW), .AW(AW), .IDW(IDW), .DEV_ID(DEV_ID)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sclk_s   (pins_s[1]),
    .sen_n_s  (pins_s[2]),
    .sdio_s   (pins_s[0]),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdio_o   (sdio_o),
    .sdio_oe_o(sdio_oe_o)
  );

  tw_regs #(.DW(DW), .AW(AW), .NUM_ARGS(NUM_ARGS), .NUM_RESP(NUM_RESP),
            .CMD_IDX(CMD_IDX), .ARG_IDX(ARG_IDX), .RESP_IDX(RESP_IDX)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .we_i      (wr_en),
    .waddr_i   (wr_addr),
    .wdata_i   (wr_data),
    .raddr_i   (rd_addr),
    .resp_i    (resp_i),
    .rdata_o   (rd_data),
    .cmd_go_o  (cmd_go_o),
    .cmd_word_o(cmd_word_o),
    .args_o    (args_o)
  );
endmodule

// File: tb/tb_tw_slave.sv
module tb_tw_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdio_h = 1'b0;
  logic sdio_o, sdio_oe, cmd_go;
  logic [15:0] cmd_word;
  logic [47:0] args;
  logic [127:0] resp;

  int total = 0, bad = 0;
  bit oe_any = 0;
  logic [63:0] exp_q [$];

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < 8; k++) resp[k*16 +: 16] = 16'hC000 + 16'(k) * 16'h0111;

  tw_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sen_n_i(sen_n), .sdio_i(sdio_h),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .resp_i(resp),
    .cmd_go_o(cmd_go), .cmd_word_o(cmd_word), .args_o(args)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected command launches as the strobe appears
  always @(negedge clk) begin
    if (sdio_oe) oe_any = 1'b1;
    if (rst_n && cmd_go) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R4/R9 unexpected strobe", {16'h0, cmd_word}, 32'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(cmd_word == e[63:48], "R3 cmd word at strobe", {16'h0, cmd_word}, {16'h0, e[63:48]});
        chk(args == e[47:0], "R3 args at strobe", args[31:0], e[31:0]);
      end
    end
  end

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sclk = 1'b0; sdio_h = b; half();
    sclk = 1'b1; half();
  endtask

  task automatic close_ok();
    sclk = 1'b0; half();
    sen_n = 1'b1; half();
    sclk = 1'b1; half();
    sclk = 1'b0; half();
  endtask

  task automatic send_ctrl(input logic [2:0] id, input logic rw, input logic [4:0] a);
    logic [8:0] c;
    c = {id, rw, a};
    for (int i = 8; i >= 0; i--) put_bit(c[i]);
  endtask

  task automatic wr(input logic [2:0] id, input logic [4:0] a, input logic [15:0] d, input int nbits);
    sen_n = 1'b0; half();
    send_ctrl(id, 1'b0, a);
    for (int i = 0; i < nbits; i++) put_bit(d[15-i]);
    close_ok();
  endtask

  task automatic rd(input logic [2:0] id, input logic [4:0] a, output logic [15:0] w,
                    output bit oe_all, output bit oe_early, output bit oe_late);
    sen_n = 1'b0; half();
    send_ctrl(id, 1'b1, a);
    oe_early = sdio_oe;
    oe_all = 1'b1;
    sdio_h = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0;
      repeat (5) @(negedge clk);
      w[15-i] = sdio_o;
      if (!sdio_oe) oe_all = 1'b0;
      @(negedge clk);
      sclk = 1'b1; half();
    end
    close_ok();
    repeat (4) @(negedge clk);
    oe_late = sdio_oe;
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] w; bit all, early, late;
    rd(3'b101, a, w, all, early, late);
    chk(w == exp, tag, {16'h0, w}, {16'h0, exp});
    chk(all && !early && !late, "R5 oe window", {29'h0, all, early, late}, 32'h4);
  endtask

  function automatic logic [15:0] arg_w(input int k);
    return args[k*16 +: 16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [15:0] w; bit all, early, late;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(!cmd_go && !sdio_oe, "R1 strobe/oe low", {30'h0, cmd_go, sdio_oe}, 32'h0);
    chk(cmd_word == 16'h0, "R1 cmd word", {16'h0, cmd_word}, 32'h0);
    chk(args == 48'h0, "R1 args", args[31:0], 32'h0);

    // R2 argument writes
    wr(3'b101, 5'h01, 16'h1234, 16);
    wr(3'b101, 5'h02, 16'hBEEF, 16);
    wr(3'b101, 5'h03, 16'h0F0F, 16);
    chk(arg_w(0) == 16'h1234, "R2 arg0", {16'h0, arg_w(0)}, 32'h1234);
    chk(arg_w(1) == 16'hBEEF, "R2 arg1", {16'h0, arg_w(1)}, 32'hBEEF);
    chk(arg_w(2) == 16'h0F0F, "R2 arg2", {16'h0, arg_w(2)}, 32'h0F0F);

    // R3 command launch
    exp_q.push_back({16'h00A5, 16'h0F0F, 16'hBEEF, 16'h1234});
    wr(3'b101, 5'h00, 16'h00A5, 16);
    chk(exp_q.size() == 0, "R3 strobe seen", exp_q.size(), 32'h0);

    // R4 aborted writes
    wr(3'b101, 5'h01, 16'hFFFF, 10);
    chk(arg_w(0) == 16'h1234, "R4 arg0 kept", {16'h0, arg_w(0)}, 32'h1234);
    wr(3'b101, 5'h00, 16'h5A5A, 15);
    chk(cmd_word == 16'h00A5, "R4 cmd kept", {16'h0, cmd_word}, 32'h00A5);

    // R5/R6 reads
    rd_check(5'h02, 16'hBEEF, "R6 read arg1");
    rd_check(5'h00, 16'h00A5, "R6 read cmd");
    rd_check(5'h08, 16'hC000, "R6 read resp0");
    rd_check(5'h0F, 16'hC777, "R6 read resp7");

    // R7 unmapped read
    rd_check(5'h05, 16'h0000, "R7 unmapped read");
    rd_check(5'h1F, 16'h0000, "R7 unmapped read top");

    // R8 wrong device ID
    wr(3'b100, 5'h01, 16'hFFFF, 16);
    chk(arg_w(0) == 16'h1234, "R8 bad id write ignored", {16'h0, arg_w(0)}, 32'h1234);
    oe_any = 1'b0;
    rd(3'b001, 5'h02, w, all, early, late);
    chk(!oe_any, "R8 bad id no drive", {31'h0, oe_any}, 32'h0);

    // R9 writes to read-only and unmapped indexes
    wr(3'b101, 5'h09, 16'h1111, 16);
    wr(3'b101, 5'h06, 16'h2222, 16);
    wr(3'b101, 5'h1F, 16'h3333, 16);
    chk(args == {16'h0F0F, 16'hBEEF, 16'h1234}, "R9 args kept", args[31:0], 32'hBEEF1234);
    chk(cmd_word == 16'h00A5, "R9 cmd kept", {16'h0, cmd_word}, 32'h00A5);
    rd_check(5'h09, 16'hC111, "R9 resp unchanged");

    // R10 frame without closing pulse is followed by an ignored frame
    sen_n = 1'b0; half();
    send_ctrl(3'b101, 1'b0, 5'h01);
    for (int i = 0; i < 16; i++) put_bit(1'(16'hAAAA >> (15 - i)));
    sclk = 1'b0; half();
    sen_n = 1'b1; half();
    sen_n = 1'b0; half();
    send_ctrl(3'b101, 1'b0, 5'h01);
    for (int i = 0; i < 16; i++) put_bit(1'(16'h5555 >> (15 - i)));
    close_ok();
    chk(arg_w(0) == 16'hAAAA, "R10 unclosed frame ignored", {16'h0, arg_w(0)}, 32'hAAAA);
    wr(3'b101, 5'h01, 16'h7777, 16);
    chk(arg_w(0) == 16'h7777, "R10 normal frame after close", {16'h0, arg_w(0)}, 32'h7777);

    // R3 second launch with new arguments
    exp_q.push_back({16'hC3C3, 16'h0F0F, 16'hBEEF, 16'h7777});
    wr(3'b101, 5'h00, 16'hC3C3, 16);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3 second strobe seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule